// File: doc/BRIEF.md
# Virtual Address Translation Front End

This block stands between a load/store or fetch unit and the TLB. It accepts one translation request at a time through a valid/ready handshake. The request carries a virtual address, an access kind, a privilege mode and two mode-control bits. The block first resolves everything that needs no page table. That covers untranslated direct addressing, four privilege-qualified direct-map windows keyed on the upper address bits, and rejection of non-canonical addresses. Only the remaining requests are forwarded to the TLB.

When the TLB replies with a result code, the block turns that code into an exception number that depends on the access kind. It also records the faulting address. A TLB miss goes to a dedicated refill register set, so a refill handler can run without disturbing the state of an ordinary fault. All other faults go to the ordinary bad-address and entry-high registers. A debug hold input suppresses the bad-address write.

Every response is a single-cycle pulse. A response that is resolved locally arrives one cycle after acceptance. A response that needs the TLB arrives one cycle after the TLB reply.

Top module: `vat_front`

## Requirements
- R1: When `direct_en`=1 and `paging_en`=0, the response is: path 0, `rsp_paddr` = `req_vaddr[PA_W-1:0]`, `rsp_prot`=3'b111 (bit0 read, bit1 write, bit2 execute), no fault, `rsp_exc`=0. It arrives one cycle after acceptance, and the windows are ignored.
- R2: In any other mode, window i hits when two conditions hold. Its enable bit for the current mode is set: `win_en_k[i]` in kernel mode (`req_user`=0), `win_en_u[i]` in user mode. Its field `win_hi[i*HI_W +: HI_W]` equals `req_vaddr[VA_W-1:VSPACE_W]`. A hit responds with path 1, the same address and permissions as R1, and no fault.
- R3: When several windows hit, `rsp_win` reports the lowest hitting index. `rsp_win` is 0 on every other path.
- R4: With no window hit, the upper bits `req_vaddr[VA_W-1:VSPACE_W]` must be all zeros or all ones. Otherwise the response is path 3 with a fault: `rsp_exc`=8 for a fetch (access 2) and 9 for a load (0) or store (1). No TLB request is made.
- R5: A request that reaches the TLB raises `tlb_req_valid` in the cycle after acceptance, with the captured address and access kind. It holds them until `tlb_rsp_valid`. `req_ready` stays low until the response has been given. The response is path 2.
- R6: TLB result code 0 (match) gives no fault, `rsp_exc`=0, and `rsp_paddr`/`rsp_prot` taken from the TLB. Any fault response carries `rsp_paddr`=0 and `rsp_prot`=0.
- R7: TLB codes 2 (no match) and 3 (invalid entry) give exception 1 for a load, 2 for a store and 3 for a fetch.
- R8: TLB code 4 (store to clean page) gives 4, code 5 (read inhibited) gives 5, code 6 (execute inhibited) gives 6, code 7 (privilege violation) gives 7, and code 1 (bad address) maps as in R4.
- R9: A no-match fault sets `refill_flag`, loads `refill_badv` with the address and `refill_vppn` with address bits [VSPACE_W-1:PAGE_SHIFT+1]. The ordinary registers are left unchanged.
- R10: Every other fault (R4, and TLB codes 1, 3 to 7) clears `refill_flag`. It loads `flt_ehi` with the address with bits [PAGE_SHIFT:0] cleared, and loads `flt_badv` with the address unless `dbg_hold`=1. The refill address registers are left unchanged.
- R11: After reset, `req_ready`=1, `rsp_valid`=0, `tlb_req_valid`=0, and all fault registers and `refill_flag` are 0.
- R12: `rsp_valid` is high for exactly one cycle per accepted request, and `req_ready` returns high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| direct_en | input | 1 | Direct addressing enable |
| paging_en | input | 1 | Paging enable |
| dbg_hold | input | 1 | Suppress ordinary bad-address capture |
| win_en_k | input | NUM_WIN | Per-window kernel enable |
| win_en_u | input | NUM_WIN | Per-window user enable |
| win_hi | input | NUM_WIN*HI_W | Per-window upper-bit match value |
| tlb_req_valid | output | 1 | TLB lookup request |
| tlb_req_vaddr | output | VA_W | Address to look up |
| tlb_req_acc | output | 2 | Access kind to look up |
| tlb_rsp_valid | input | 1 | TLB result valid |
| tlb_rsp_code | input | 3 | TLB result code |
| tlb_rsp_paddr | input | PA_W | Physical address on match |
| tlb_rsp_prot | input | 3 | Permissions on match |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_exc | output | 4 | Exception number |
| rsp_paddr | output | PA_W | Physical address |
| rsp_prot | output | 3 | Permissions |
| rsp_path | output | 2 | 0 direct, 1 window, 2 TLB, 3 bad address |
| rsp_win | output | WIN_IDX_W | Hitting window index |
| refill_flag | output | 1 | Last fault was a TLB miss |
| refill_badv | output | VA_W | Refill faulting address |
| refill_vppn | output | VPPN_W | Refill virtual double-page number |
| flt_badv | output | VA_W | Ordinary faulting address |
| flt_ehi | output | VA_W | Ordinary entry-high (double-page aligned) |

## Verification
The bench builds the block with its defaults: a 64-bit virtual address, a 48-bit virtual space, a 48-bit physical address, four windows and 4 KiB pages. These values give a 16-bit upper field. Biasing that field toward 0, all ones, a configured window value or a random pattern reaches canonical, non-canonical and window-hit cases in similar numbers. Four windows whose values are often repeated make overlapping hits frequent, which exercises the lowest-index priority. A 35-bit refill page number and a 13-bit entry-high mask are checked against addresses with random low bits.

// File: rtl/vat_pkg.sv
package vat_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   // Result codes returned by the TLB; the values are the interface contract
   typedef enum logic [2:0] {
      TR_OK      = 3'd0,
      TR_BADADDR = 3'd1,
      TR_NOMATCH = 3'd2,
      TR_INVALID = 3'd3,
      TR_DIRTY   = 3'd4,
      TR_NOREAD  = 3'd5,
      TR_NOEXEC  = 3'd6,
      TR_PRIV    = 3'd7
   } tres_e;

   typedef enum logic [3:0] {
      EX_NONE     = 4'd0,
      EX_PINV_LD  = 4'd1,
      EX_PINV_ST  = 4'd2,
      EX_PINV_IF  = 4'd3,
      EX_MODIFY   = 4'd4,
      EX_NOREAD   = 4'd5,
      EX_NOEXEC   = 4'd6,
      EX_PRIV     = 4'd7,
      EX_ADDR_IF  = 4'd8,
      EX_ADDR_MEM = 4'd9
   } exc_e;

   typedef enum logic [1:0] {
      PATH_DIRECT = 2'd0,
      PATH_WINDOW = 2'd1,
      PATH_TLB    = 2'd2,
      PATH_BAD    = 2'd3
   } path_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_DONE   = 2'd2
   } state_e;

endpackage

// File: rtl/vat_win_match.sv
module vat_win_match #(
   parameter int HI_W      = 16,
   parameter int NUM_WIN   = 4,
   parameter int IDX_W     = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [HI_W-1:0]         addr_hi,
   input  logic                    user,
   input  logic [NUM_WIN-1:0]      en_k,
   input  logic [NUM_WIN-1:0]      en_u,
   input  logic [NUM_WIN*HI_W-1:0] bases,
   output logic                    hit,
   output logic [IDX_W-1:0]        idx
);

   logic [NUM_WIN-1:0] hv;

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic mode_ok;
      assign mode_ok = user ? en_u[i] : en_k[i];
      assign hv[i]   = mode_ok && (bases[i*HI_W +: HI_W] == addr_hi);
   end

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         idx = '0;
         for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hv[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_high_first
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_WIN; i++) begin
            if (hv[i]) idx = IDX_W'(i);
         end
      end
   end

   assign hit = |hv;

endmodule

// File: rtl/vat_canon_chk.sv
module vat_canon_chk #(
   parameter int HI_W = 16
) (
   input  logic [HI_W-1:0] hi,
   output logic            ok
);

   assign ok = (&hi) | (~|hi);

endmodule

// File: rtl/vat_exc_map.sv
module vat_exc_map
   import vat_pkg::*;
(
   input  tres_e code,
   input  acc_e  acc,
   output exc_e  exc,
   output logic  fault,
   output logic  refill
);

   always_comb begin
      unique case (code)
         TR_OK: exc = EX_NONE;
         TR_NOMATCH, TR_INVALID: begin
            case (acc)
               ACC_STORE: exc = EX_PINV_ST;
               ACC_FETCH: exc = EX_PINV_IF;
               default:   exc = EX_PINV_LD;
            endcase
         end
         TR_DIRTY:  exc = EX_MODIFY;
         TR_NOREAD: exc = EX_NOREAD;
         TR_NOEXEC: exc = EX_NOEXEC;
         TR_PRIV:   exc = EX_PRIV;
         default:   exc = (acc == ACC_FETCH) ? EX_ADDR_IF : EX_ADDR_MEM;
      endcase
   end

   assign fault  = (code != TR_OK);
   assign refill = (code == TR_NOMATCH);

endmodule

// File: rtl/vat_front.sv
module vat_front
   import vat_pkg::*;
#(
   parameter int VA_W          = 64,
   parameter int VSPACE_W      = 48,
   parameter int PA_W          = 48,
   parameter int NUM_WIN       = 4,
   parameter int PAGE_SHIFT    = 12,
   parameter bit LOW_WIN_FIRST = 1'b1,
   localparam int HI_W      = VA_W - VSPACE_W,
   localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int DP_SH     = PAGE_SHIFT + 1,
   localparam int VPPN_W    = VSPACE_W - DP_SH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [VA_W-1:0]         req_vaddr,
   input  logic [1:0]              req_acc,
   input  logic                    req_user,
   input  logic                    direct_en,
   input  logic                    paging_en,
   input  logic                    dbg_hold,
   input  logic [NUM_WIN-1:0]      win_en_k,
   input  logic [NUM_WIN-1:0]      win_en_u,
   input  logic [NUM_WIN*HI_W-1:0] win_hi,
   output logic                    tlb_req_valid,
   output logic [VA_W-1:0]         tlb_req_vaddr,
   output logic [1:0]              tlb_req_acc,
   input  logic                    tlb_rsp_valid,
   input  logic [2:0]              tlb_rsp_code,
   input  logic [PA_W-1:0]         tlb_rsp_paddr,
   input  logic [2:0]              tlb_rsp_prot,
   output logic                    rsp_valid,
   output logic                    rsp_fault,
   output logic [3:0]              rsp_exc,
   output logic [PA_W-1:0]         rsp_paddr,
   output logic [2:0]              rsp_prot,
   output logic [1:0]              rsp_path,
   output logic [WIN_IDX_W-1:0]    rsp_win,
   output logic                    refill_flag,
   output logic [VA_W-1:0]         refill_badv,
   output logic [VPPN_W-1:0]       refill_vppn,
   output logic [VA_W-1:0]         flt_badv,
   output logic [VA_W-1:0]         flt_ehi
);

   initial begin
      if (PA_W > VSPACE_W || HI_W < 1 || NUM_WIN < 1 || DP_SH >= VSPACE_W)
         $fatal(1, "vat_front: inconsistent width parameters");
   end

   state_e               state;
   logic [VA_W-1:0]      rq_vaddr;
   logic [1:0]           rq_acc;

   logic                 acc_fire;
   logic                 loc_direct;
   logic                 win_hit;
   logic [WIN_IDX_W-1:0] win_idx;
   logic                 canon_ok;
   logic                 in_lookup;
   tres_e                map_code;
   acc_e                 map_acc;
   exc_e                 map_exc;
   logic                 map_fault;
   logic                 map_refill;
   logic [VA_W-1:0]      flt_vaddr;
   logic                 fault_evt;

   assign req_ready     = (state == ST_IDLE);
   assign rsp_valid     = (state == ST_DONE);
   assign in_lookup     = (state == ST_LOOKUP);
   assign tlb_req_valid = in_lookup;
   assign tlb_req_vaddr = rq_vaddr;
   assign tlb_req_acc   = rq_acc;

   assign acc_fire   = req_valid && req_ready;
   assign loc_direct = direct_en && !paging_en;

   vat_win_match #(
      .HI_W      (HI_W),
      .NUM_WIN   (NUM_WIN),
      .IDX_W     (WIN_IDX_W),
      .LOW_FIRST (LOW_WIN_FIRST)
   ) win_i (
      .addr_hi (req_vaddr[VA_W-1:VSPACE_W]),
      .user    (req_user),
      .en_k    (win_en_k),
      .en_u    (win_en_u),
      .bases   (win_hi),
      .hit     (win_hit),
      .idx     (win_idx)
   );

   vat_canon_chk #(.HI_W(HI_W)) canon_i (
      .hi (req_vaddr[VA_W-1:VSPACE_W]),
      .ok (canon_ok)
   );

   // One mapper serves both the local bad-address case and the TLB reply
   assign map_code  = in_lookup ? tres_e'(tlb_rsp_code) : TR_BADADDR;
   assign map_acc   = in_lookup ? acc_e'(rq_acc) : acc_e'(req_acc);
   assign flt_vaddr = in_lookup ? rq_vaddr : req_vaddr;

   vat_exc_map exc_i (
      .code   (map_code),
      .acc    (map_acc),
      .exc    (map_exc),
      .fault  (map_fault),
      .refill (map_refill)
   );

   assign fault_evt = (acc_fire && !loc_direct && !win_hit && !canon_ok)
                    || (in_lookup && tlb_rsp_valid && map_fault);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rq_vaddr  <= '0;
         rq_acc    <= '0;
         rsp_fault <= 1'b0;
         rsp_exc   <= '0;
         rsp_paddr <= '0;
         rsp_prot  <= '0;
         rsp_path  <= '0;
         rsp_win   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (acc_fire) begin
                  rq_vaddr <= req_vaddr;
                  rq_acc   <= req_acc;
                  rsp_win  <= '0;
                  if (loc_direct || win_hit) begin
                     state     <= ST_DONE;
                     rsp_fault <= 1'b0;
                     rsp_exc   <= EX_NONE;
                     rsp_paddr <= req_vaddr[PA_W-1:0];
                     rsp_prot  <= 3'b111;
                     rsp_path  <= loc_direct ? PATH_DIRECT : PATH_WINDOW;
                     if (!loc_direct) rsp_win <= win_idx;
                  end else if (!canon_ok) begin
                     state     <= ST_DONE;
                     rsp_fault <= 1'b1;
                     rsp_exc   <= map_exc;
                     rsp_paddr <= '0;
                     rsp_prot  <= '0;
                     rsp_path  <= PATH_BAD;
                  end else begin
                     state <= ST_LOOKUP;
                  end
               end
            end
            ST_LOOKUP: begin
               if (tlb_rsp_valid) begin
                  state     <= ST_DONE;
                  rsp_fault <= map_fault;
                  rsp_exc   <= map_exc;
                  rsp_paddr <= map_fault ? '0 : tlb_rsp_paddr;
                  rsp_prot  <= map_fault ? '0 : tlb_rsp_prot;
                  rsp_path  <= PATH_TLB;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Fault capture: refill set on a miss, ordinary set on everything else
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         refill_flag <= 1'b0;
         refill_badv <= '0;
         refill_vppn <= '0;
         flt_badv    <= '0;
         flt_ehi     <= '0;
      end else if (fault_evt) begin
         if (map_refill) begin
            refill_flag <= 1'b1;
            refill_badv <= flt_vaddr;
            refill_vppn <= flt_vaddr[VSPACE_W-1:DP_SH];
         end else begin
            refill_flag <= 1'b0;
            if (!dbg_hold) flt_badv <= flt_vaddr;
            flt_ehi <= {flt_vaddr[VA_W-1:DP_SH], {DP_SH{1'b0}}};
         end
      end
   end

endmodule

// File: rtl/vat_front_chk.sv
module vat_front_chk #(
   parameter int VA_W       = 64,
   parameter int VSPACE_W   = 48,
   parameter int PAGE_SHIFT = 12,
   localparam int DP_SH     = PAGE_SHIFT + 1,
   localparam int VPPN_W    = VSPACE_W - DP_SH
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              tlb_req_valid,
   input logic              tlb_rsp_valid,
   input logic              rsp_valid,
   input logic              rsp_fault,
   input logic [3:0]        rsp_exc,
   input logic [2:0]        rsp_prot,
   input logic [1:0]        rsp_path,
   input logic              refill_flag,
   input logic [VA_W-1:0]   refill_badv,
   input logic [VPPN_W-1:0] refill_vppn
);

   AST_DIRECT_FULL_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path == 2'd0) |-> (rsp_prot == 3'b111 && !rsp_fault)); // R1

   AST_BAD_ADDR_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_path == 2'd3) |-> (rsp_exc == 4'd8 || rsp_exc == 4'd9)); // R4

   AST_TLB_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tlb_req_valid) |-> $past(req_valid && req_ready)); // R5

   AST_TLB_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_req_valid && !tlb_rsp_valid) |=> tlb_req_valid); // R5

   AST_FAULT_EXC_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_exc != 4'd0))); // R8

   AST_REFILL_VPPN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      refill_flag |-> (refill_vppn == refill_badv[VSPACE_W-1:DP_SH])); // R9

   AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R12

endmodule

bind vat_front vat_front_chk #(
   .VA_W       (VA_W),
   .VSPACE_W   (VSPACE_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .tlb_req_valid (tlb_req_valid),
   .tlb_rsp_valid (tlb_rsp_valid),
   .rsp_valid     (rsp_valid),
   .rsp_fault     (rsp_fault),
   .rsp_exc       (rsp_exc),
   .rsp_prot      (rsp_prot),
   .rsp_path      (rsp_path),
   .refill_flag   (refill_flag),
   .refill_badv   (refill_badv),
   .refill_vppn   (refill_vppn)
);

// File: tb/vat_front_tb_top.sv
module vat_front_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic        direct_en = 1'b0;
   logic        paging_en = 1'b0;
   logic        dbg_hold = 1'b0;
   logic [3:0]  win_en_k = '0;
   logic [3:0]  win_en_u = '0;
   logic [63:0] win_hi;
   logic        tlb_req_valid;
   logic [63:0] tlb_req_vaddr;
   logic [1:0]  tlb_req_acc;
   logic        tlb_rsp_valid = 1'b0;
   logic [2:0]  tlb_rsp_code = '0;
   logic [47:0] tlb_rsp_paddr = '0;
   logic [2:0]  tlb_rsp_prot = '0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [3:0]  rsp_exc;
   logic [47:0] rsp_paddr;
   logic [2:0]  rsp_prot;
   logic [1:0]  rsp_path;
   logic [1:0]  rsp_win;
   logic        refill_flag;
   logic [63:0] refill_badv;
   logic [34:0] refill_vppn;
   logic [63:0] flt_badv;
   logic [63:0] flt_ehi;

   logic [15:0] whi [4];
   assign win_hi = {whi[3], whi[2], whi[1], whi[0]};

   int checks = 0;
   int errors = 0;

   logic        m_rf = 1'b0;
   logic [63:0] m_rbadv = '0;
   logic [34:0] m_rvppn = '0;
   logic [63:0] m_badv = '0;
   logic [63:0] m_ehi = '0;

   always #5 clk = ~clk;

   vat_front dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
      .direct_en(direct_en), .paging_en(paging_en), .dbg_hold(dbg_hold),
      .win_en_k(win_en_k), .win_en_u(win_en_u), .win_hi(win_hi),
      .tlb_req_valid(tlb_req_valid), .tlb_req_vaddr(tlb_req_vaddr),
      .tlb_req_acc(tlb_req_acc), .tlb_rsp_valid(tlb_rsp_valid),
      .tlb_rsp_code(tlb_rsp_code), .tlb_rsp_paddr(tlb_rsp_paddr),
      .tlb_rsp_prot(tlb_rsp_prot), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_exc(rsp_exc), .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot),
      .rsp_path(rsp_path), .rsp_win(rsp_win), .refill_flag(refill_flag),
      .refill_badv(refill_badv), .refill_vppn(refill_vppn),
      .flt_badv(flt_badv), .flt_ehi(flt_ehi)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exc_of(input logic [2:0] code, input logic [1:0] acc);
      case (code)
         3'd0: return 4'd0;
         3'd2, 3'd3: return (acc == 2'd1) ? 4'd2 : (acc == 2'd2) ? 4'd3 : 4'd1;
         3'd4: return 4'd4;
         3'd5: return 4'd5;
         3'd6: return 4'd6;
         3'd7: return 4'd7;
         default: return (acc == 2'd2) ? 4'd8 : 4'd9;
      endcase
   endfunction

   task automatic ord_fault(input logic [63:0] va, input logic dbg);
      m_rf = 1'b0;
      if (!dbg) m_badv = va;
      m_ehi = va & ~64'h1FFF;
   endtask

   task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic usr,
                      input logic da, input logic pg, input logic dbg,
                      input logic [2:0] code, input logic [47:0] tpa,
                      input logic [2:0] tprot, input int dly);
      logic [15:0] hi;
      int          w;
      logic [1:0]  e_path;
      logic        e_fault;
      logic [3:0]  e_exc;
      logic [47:0] e_pa;
      logic [2:0]  e_prot;
      string       tag;
      hi = va[63:48];
      w  = -1;
      if (!(da && !pg)) begin
         for (int i = 0; i < 4; i++)
            if (w < 0 && (usr ? win_en_u[i] : win_en_k[i]) && whi[i] == hi) w = i;
      end
      e_fault = 1'b0; e_exc = 4'd0; e_pa = va[47:0]; e_prot = 3'b111;
      if (da && !pg) begin
         e_path = 2'd0; tag = "R1";
      end else if (w >= 0) begin
         e_path = 2'd1; tag = "R2";
      end else if (!(hi == 16'h0 || hi == 16'hFFFF)) begin
         e_path = 2'd3; tag = "R4"; e_fault = 1'b1; e_exc = (acc == 2'd2) ? 4'd8 : 4'd9;
         e_pa = '0; e_prot = '0;
         ord_fault(va, dbg);
      end else begin
         e_path = 2'd2;
         tag = (code == 3'd0) ? "R6" : (code == 3'd2 || code == 3'd3) ? "R7" : "R8";
         e_exc = exc_of(code, acc);
         e_fault = (code != 3'd0);
         e_pa = e_fault ? 48'h0 : tpa;
         e_prot = e_fault ? 3'b000 : tprot;
         if (code == 3'd2) begin
            m_rf = 1'b1; m_rbadv = va; m_rvppn = va[47:13];
         end else if (code != 3'd0) begin
            ord_fault(va, dbg);
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
      direct_en = da; paging_en = pg; dbg_hold = dbg;
      @(negedge clk);
      req_valid = 1'b0;
      if (e_path == 2'd2) begin
         chk("R5 tlb_req_valid", {63'd0, tlb_req_valid}, 64'd1);
         chk("R5 tlb_req_vaddr", tlb_req_vaddr, va);
         chk("R5 tlb_req_acc", {62'd0, tlb_req_acc}, {62'd0, acc});
         chk("R5 req_ready low", {63'd0, req_ready}, 64'd0);
         repeat (dly) @(negedge clk);
         chk("R5 tlb_req held", {63'd0, tlb_req_valid}, 64'd1);
         chk("R5 no early rsp", {63'd0, rsp_valid}, 64'd0);
         tlb_rsp_valid = 1'b1; tlb_rsp_code = code; tlb_rsp_paddr = tpa; tlb_rsp_prot = tprot;
         @(negedge clk);
         tlb_rsp_valid = 1'b0;
      end else begin
         chk({tag, " no tlb request"}, {63'd0, tlb_req_valid}, 64'd0);
      end
      chk({tag, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
      chk({tag, " rsp_path"}, {62'd0, rsp_path}, {62'd0, e_path});
      chk({tag, " rsp_fault"}, {63'd0, rsp_fault}, {63'd0, e_fault});
      chk({tag, " rsp_exc"}, {60'd0, rsp_exc}, {60'd0, e_exc});
      chk({tag, " rsp_paddr"}, {16'd0, rsp_paddr}, {16'd0, e_pa});
      chk({tag, " rsp_prot"}, {61'd0, rsp_prot}, {61'd0, e_prot});
      chk("R3 rsp_win", {62'd0, rsp_win}, (w >= 0 && e_path == 2'd1) ? 64'(w) : 64'd0);
      chk("R9 refill_flag", {63'd0, refill_flag}, {63'd0, m_rf});
      chk("R9 refill_badv", refill_badv, m_rbadv);
      chk("R9 refill_vppn", {29'd0, refill_vppn}, {29'd0, m_rvppn});
      chk("R10 flt_badv", flt_badv, m_badv);
      chk("R10 flt_ehi", flt_ehi, m_ehi);
      @(negedge clk);
      chk("R12 rsp pulse ends", {63'd0, rsp_valid}, 64'd0);
      chk("R12 ready again", {63'd0, req_ready}, 64'd1);
   endtask

   task automatic rand_cfg();
      for (int i = 0; i < 4; i++) begin
         case ($urandom % 3)
            0: whi[i] = 16'h9000;
            1: whi[i] = 16'(($urandom % 4) * 16'h1111);
            default: whi[i] = 16'($urandom);
         endcase
      end
      win_en_k = 4'($urandom);
      win_en_u = 4'($urandom);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] va;
      logic [15:0] hi;
      void'($urandom(32'd4242));
      for (int i = 0; i < 4; i++) whi[i] = 16'h0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 req_ready", {63'd0, req_ready}, 64'd1);
      chk("R11 rsp_valid", {63'd0, rsp_valid}, 64'd0);
      chk("R11 tlb_req_valid", {63'd0, tlb_req_valid}, 64'd0);
      chk("R11 refill_flag", {63'd0, refill_flag}, 64'd0);
      chk("R11 flt_badv", flt_badv, 64'd0);
      chk("R11 flt_ehi", flt_ehi, 64'd0);
      rst_n = 1'b1;

      // R1 direct mode ignores windows and canonical form
      whi[0] = 16'h9000; win_en_k = 4'b0001; win_en_u = 4'b0000;
      run(64'h9000_1234_5678_9ABC, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      run(64'h5555_0000_0000_1000, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      // R2 kernel window hit, then same address in user mode misses (bad address)
      run(64'h9000_0000_ABCD_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      run(64'h9000_0000_ABCD_0000, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      // R3 overlapping windows 1 and 3
      whi[1] = 16'h8000; whi[3] = 16'h8000; win_en_u = 4'b1010;
      run(64'h8000_0000_0000_4000, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      // R4 / R10 bad address with debug hold keeps flt_badv
      run(64'h1234_0000_0000_3FFF, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 48'h0, 3'd0, 0);
      run(64'h4321_0000_0000_7FFF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 48'h0, 3'd0, 0);
      // R6-R9 every TLB code with every access kind
      for (int c = 0; c < 8; c++)
         for (int a = 0; a < 3; a++)
            run(64'hFFFF_8000_0000_0000 | 64'(c * 4096 + a * 17), 2'(a), 1'b0, 1'b0, 1'b1,
                1'b0, 3'(c), 48'hABC_DEF0_1000 + 48'(c), 3'(a + 1), c % 3);

      for (int n = 0; n < 400; n++) begin
         if (n % 20 == 0) rand_cfg();
         case ($urandom % 4)
            0: hi = 16'h0;
            1: hi = 16'hFFFF;
            2: hi = whi[$urandom % 4];
            default: hi = 16'($urandom);
         endcase
         va = {hi, 16'($urandom), 32'($urandom)};
         run(va, 2'($urandom % 3), 1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom),
             1'(($urandom % 4) == 0), 3'($urandom), 48'({$urandom, $urandom}),
             3'($urandom), $urandom % 4);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule